// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block gathers eight device request lines and presents one interrupt request to a processor. When the processor pulses the acknowledge input, the controller grants the best eligible source. It then records that source as in service and, from the next cycle on, presents an 8-bit vector. The vector is a programmable 5-bit base followed by the 3-bit index of the granted line. Software sets the controller up through a four-register write port. Through that port it can mask individual lines, choose edge or level triggering per line, pick fixed or rotating priority, set the vector base and enable the cascade hook. A write to the command register ends the current service.

In both priority schemes, a request reaches the processor only if it outranks every source already in service. This gives fully nested handling. In fixed mode line 0 ranks highest and line 7 lowest. In rotating mode the ranking is circular, and the source most recently released by end-of-interrupt becomes the lowest. One line, index 2 by default, can be marked as the attachment point of a second controller. A grant on that line raises a flag so that the downstream controller can supply the vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irqOut, vectorOut and cascadeHit are 0. All lines are masked, all lines are edge-triggered, priority is fixed, the vector base is 0 and no source is in service.
- R2: A write with regWrEn high takes effect on the next clock edge. Address 0 is the mask (bit i = 1 masks line i). Address 1 is the trigger mode (bit i = 1 makes line i level-triggered, 0 edge-triggered). Address 2 is the configuration: bit 0 selects rotating priority, bit 1 enables cascade, and bits 7:3 hold the vector base. Any write to address 3 is a non-specific end-of-interrupt.
- R3: On an edge-triggered line, a rising input is latched as a request. The request stays pending after the input falls, until the line is granted.
- R4: On a level-triggered line, the request follows the input. Dropping the input before acknowledge withdraws the request, and irqOut falls in the same cycle.
- R5: A masked line never drives irqOut and is never granted. A rising edge seen while the line is masked is kept and becomes visible once the line is unmasked.
- R6: irqOut is high exactly when some unmasked pending request ranks strictly higher than every in-service source. Equal and lower ranks are held off.
- R7: An acknowledge while irqOut is high sets the in-service bit of the highest-ranked eligible request and clears its edge latch. From the next cycle, vectorOut equals {base, index}. vectorOut holds until the next acknowledge.
- R8: An acknowledge while irqOut is low changes no in-service bit or latch. It yields vectorOut = {base, 3'b111} and cascadeHit = 0.
- R9: With fixed priority, line 0 ranks highest and line 7 lowest.
- R10: With rotating priority, ranking starts at the line after a pointer and wraps around. The pointer resets to 7. Each end-of-interrupt in rotating mode moves the pointer to the line it released, which makes that line the lowest.
- R11: End-of-interrupt clears the highest-ranked in-service bit. When no source is in service it has no effect.
- R12: After a granting acknowledge, cascadeHit is 1 exactly when the granted line is the cascade line (index 2) and cascade is enabled. The flag holds until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Device request lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Register write data |
| ackStrobe | input | 1 | One-cycle acknowledge from the processor |
| irqOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 8 | Vector of the last acknowledge |
| cascadeHit | output | 1 | Last grant went to the enabled cascade line |

## Verification
A corrupted in-service set shows up at irqOut within one cycle. Either a request is wrongly held off, or a lower one leaks past a higher source still in service. A wrong rotation pointer or a lost edge latch shows up at the next acknowledge as a wrong vector index. The bench runs a behavioural model beside the block and compares all three outputs on every clock. Any divergence is therefore reported in the cycle it first reaches a port. Directed checks also pin down hand-computed vectors for nesting, rotation, withdrawal, spurious acknowledge and cascade.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_TRIG = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;
  localparam int CFG_ROT_BIT  = 0;
  localparam int CFG_CASC_BIT = 1;

  typedef struct packed {
    logic wrMask;
    logic wrTrig;
    logic wrCfg;
    logic eoi;
    logic ack;
  } irqStrobeT;
endpackage

// File: rtl/vec_irq_resolver.sv
module vec_irq_resolver #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] bits,
  input  logic [IDX_W-1:0]   lowPtr,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [IDX_W-1:0]   rank
);
  // Scan from lowest rank to highest so the last hit is the best one.
  always_comb begin
    logic [IDX_W-1:0] cand;
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      cand = lowPtr + IDX_W'(r + 1);
      if (bits[cand]) begin
        found = 1'b1;
        idx   = cand;
        rank  = IDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/vec_irq_decode.sv
module vec_irq_decode
  import vec_irq_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       ackStrobe,
  output irqStrobeT  stb
);
  always_comb begin
    stb        = '0;
    stb.ack    = ackStrobe;
    stb.wrMask = regWrEn && (regAddr == ADDR_MASK);
    stb.wrTrig = regWrEn && (regAddr == ADDR_TRIG);
    stb.wrCfg  = regWrEn && (regAddr == ADDR_CFG);
    stb.eoi    = regWrEn && (regAddr == ADDR_CMD);
  end
endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int VEC_W       = 8,
  parameter int CASCADE_IDX = 2,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [VEC_W-1:0]   wrData,
  input  irqStrobeT          stb,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vectorOut,
  output logic               cascadeHit
);
  localparam logic [IDX_W-1:0] FIXED_PTR = IDX_W'(NUM_SRC - 1);
  localparam logic [IDX_W-1:0] CASC_IDX  = IDX_W'(CASCADE_IDX);

  logic [NUM_SRC-1:0] maskReg, trigReg, edgeReq, irqPrev, isrReg;
  logic [BASE_W-1:0]  baseReg;
  logic               rotMode, cascEnReg;
  logic [IDX_W-1:0]   lowPtr, effPtr;

  logic [NUM_SRC-1:0] pending, unmasked, clearVec, riseVec;
  logic               reqFound, isrFound, grant;
  logic [IDX_W-1:0]   reqIdx, reqRank, isrIdx, isrRank;

  assign effPtr   = rotMode ? lowPtr : FIXED_PTR;
  assign pending  = (trigReg & irqIn) | (~trigReg & edgeReq);
  assign unmasked = pending & ~maskReg;
  assign riseVec  = irqIn & ~irqPrev;

  vec_irq_resolver #(.NUM_SRC(NUM_SRC)) reqPick (
    .bits(unmasked), .lowPtr(effPtr),
    .found(reqFound), .idx(reqIdx), .rank(reqRank)
  );

  vec_irq_resolver #(.NUM_SRC(NUM_SRC)) isrPick (
    .bits(isrReg), .lowPtr(effPtr),
    .found(isrFound), .idx(isrIdx), .rank(isrRank)
  );

  assign irqOut = reqFound && (!isrFound || (reqRank < isrRank));
  assign grant  = stb.ack && irqOut;

  always_comb begin
    clearVec = '0;
    if (grant) clearVec[reqIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeReq <= '0;
      irqPrev <= '0;
    end else begin
      edgeReq <= (edgeReq & ~clearVec) | riseVec;
      irqPrev <= irqIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '1;
      trigReg   <= '0;
      baseReg   <= '0;
      rotMode   <= 1'b0;
      cascEnReg <= 1'b0;
    end else begin
      if (stb.wrMask) maskReg <= wrData[NUM_SRC-1:0];
      if (stb.wrTrig) trigReg <= wrData[NUM_SRC-1:0];
      if (stb.wrCfg) begin
        baseReg   <= wrData[VEC_W-1 -: BASE_W];
        rotMode   <= wrData[CFG_ROT_BIT];
        cascEnReg <= wrData[CFG_CASC_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrReg <= '0;
      lowPtr <= FIXED_PTR;
    end else begin
      logic [NUM_SRC-1:0] isrNext;
      isrNext = isrReg;
      if (stb.eoi && isrFound) begin
        isrNext[isrIdx] = 1'b0;
        if (rotMode) lowPtr <= isrIdx;
      end
      if (grant) isrNext[reqIdx] = 1'b1;
      isrReg <= isrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vectorOut  <= '0;
      cascadeHit <= 1'b0;
    end else if (stb.ack) begin
      if (grant) begin
        vectorOut  <= {baseReg, reqIdx};
        cascadeHit <= cascEnReg && (reqIdx == CASC_IDX);
      end else begin
        vectorOut  <= {baseReg, {IDX_W{1'b1}}};
        cascadeHit <= 1'b0;
      end
    end
  end

  AST_GRANT_ADDS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && irqOut && !stb.eoi) |=> $countones(isrReg) == $past($countones(isrReg)) + 1); // R7
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && !stb.ack && (|isrReg)) |=> $countones(isrReg) + 1 == $past($countones(isrReg))); // R11
  AST_SPURIOUS_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !irqOut) |=> ((&vectorOut[IDX_W-1:0]) && !cascadeHit)); // R8
  AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> ((isrReg & ~$past(isrReg) & $past(maskReg)) == '0)); // R5
  AST_VECTOR_BASE: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> (vectorOut[VEC_W-1 -: BASE_W] == $past(baseReg))); // R7
  AST_CASCADE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> (!cascadeHit || $past(cascEnReg))); // R12
  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(edgeReq & ~clearVec) & ~edgeReq) == '0)); // R3
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int VEC_W       = 8,
  parameter int CASCADE_IDX = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [VEC_W-1:0]   regWrData,
  input  logic               ackStrobe,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vectorOut,
  output logic               cascadeHit
);
  irqStrobeT stb;

  vec_irq_decode ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .ackStrobe(ackStrobe), .stb(stb)
  );

  vec_irq_datapath #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .CASCADE_IDX(CASCADE_IDX)
  ) dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrData(regWrData), .stb(stb),
    .irqOut(irqOut), .vectorOut(vectorOut), .cascadeHit(cascadeHit)
  );
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       ackStrobe = 1'b0;
  logic       irqOut, cascadeHit;
  logic [7:0] vectorOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  vec_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ackStrobe(ackStrobe), .irqOut(irqOut),
    .vectorOut(vectorOut), .cascadeHit(cascadeHit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model
  logic [7:0] mMask, mTrig, mEdge, mPrev, mIsr, mVec;
  logic [4:0] mBase;
  bit         mRot, mCasc, mCh;
  int         mPtr;

  function automatic int effPtr();
    return mRot ? mPtr : 7;
  endfunction

  function automatic int bestOf(logic [7:0] bits);
    for (int r = 0; r < 8; r++) begin
      int i = (effPtr() + 1 + r) % 8;
      if (bits[i]) return i;
    end
    return -1;
  endfunction

  function automatic int rankOf(int i);
    return (i - effPtr() - 1 + 16) % 8;
  endfunction

  function automatic int eligible();
    logic [7:0] pend;
    int w, t;
    pend = (mTrig & irqIn) | (~mTrig & mEdge);
    w = bestOf(pend & ~mMask);
    t = bestOf(mIsr);
    if (w < 0) return -1;
    if (t >= 0 && rankOf(w) >= rankOf(t)) return -1;
    return w;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = 8'hFF; mTrig = '0; mEdge = '0; mPrev = '0; mIsr = '0;
      mVec = '0; mBase = '0; mRot = 0; mCasc = 0; mCh = 0; mPtr = 7;
    end else begin
      int w, t;
      w = eligible();
      t = bestOf(mIsr);
      mEdge = mEdge | (irqIn & ~mPrev);
      if (ackStrobe && w >= 0 && !(irqIn[w] && !mPrev[w])) mEdge[w] = 1'b0;
      mPrev = irqIn;
      if (regWrEn && regAddr == 2'd3 && t >= 0) begin
        mIsr[t] = 1'b0;
        if (mRot) mPtr = t;
      end
      if (ackStrobe) begin
        if (w >= 0) begin
          mIsr[w] = 1'b1;
          mVec = {mBase, 3'(w)};
          mCh = mCasc && (w == 2);
        end else begin
          mVec = {mBase, 3'b111};
          mCh = 0;
        end
      end
      if (regWrEn && regAddr == 2'd0) mMask = regWrData;
      if (regWrEn && regAddr == 2'd1) mTrig = regWrData;
      if (regWrEn && regAddr == 2'd2) begin
        mBase = regWrData[7:3]; mRot = regWrData[0]; mCasc = regWrData[1];
      end
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (irqOut !== (eligible() >= 0)) begin
        errors++;
        $display("FAIL R6 irqOut act %0d exp %0d at %0t", irqOut, eligible() >= 0, $time);
      end
      checks++;
      if (vectorOut !== mVec) begin
        errors++;
        $display("FAIL R7 vectorOut act %h exp %h at %0t", vectorOut, mVec, $time);
      end
      checks++;
      if (cascadeHit !== mCh) begin
        errors++;
        $display("FAIL R12 cascadeHit act %0d exp %0d at %0t", cascadeHit, mCh, $time);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nextCycle();
    @(negedge clk);
    #1;
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    nextCycle();
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic ack();
    ackStrobe = 1'b1;
    nextCycle();
    ackStrobe = 1'b0;
    #1;
  endtask

  task automatic setIrq(int i, logic v);
    irqIn[i] = v;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 irqOut in reset", irqOut, 0);
    rstN = 1'b1;
    nextCycle();
    chk("R1 irqOut", irqOut, 0);
    chk("R1 vectorOut", vectorOut, 8'h00);
    chk("R1 cascadeHit", cascadeHit, 0);

    setIrq(3, 1);
    nextCycle(); nextCycle();
    chk("R5 masked line silent", irqOut, 0);
    ack();
    chk("R8 spurious vector", vectorOut, 8'h07);

    wrReg(2'd2, 8'hA0);
    wrReg(2'd0, 8'h00);
    chk("R5 latched edge appears on unmask", irqOut, 1);
    setIrq(3, 0);
    nextCycle();
    chk("R3 edge request held", irqOut, 1);
    ack();
    chk("R7 vector base and index", vectorOut, 8'hA3);
    chk("R7 in service blocks repeat", irqOut, 0);

    setIrq(5, 1);
    nextCycle();
    chk("R6 lower rank held off", irqOut, 0);
    setIrq(1, 1);
    nextCycle();
    chk("R6 higher rank passes", irqOut, 1);
    ack();
    chk("R9 line 1 beats line 5", vectorOut, 8'hA1);
    wrReg(2'd3, 8'h00);
    chk("R11 eoi clears top only", irqOut, 0);
    wrReg(2'd3, 8'h00);
    chk("R11 second eoi frees line 5", irqOut, 1);
    ack();
    chk("R9 line 5 vector", vectorOut, 8'hA5);
    wrReg(2'd3, 8'h00);
    wrReg(2'd3, 8'h00);
    chk("R11 eoi with none in service", irqOut, 0);
    irqIn = '0; #1;

    wrReg(2'd1, 8'h10);
    setIrq(4, 1);
    nextCycle();
    chk("R4 level request", irqOut, 1);
    setIrq(4, 0);
    chk("R4 level withdrawn", irqOut, 0);
    ack();
    chk("R8 ack after withdrawal", vectorOut, 8'hA7);
    chk("R8 no cascade on spurious", cascadeHit, 0);

    wrReg(2'd2, 8'hA2);
    setIrq(2, 1);
    nextCycle();
    ack();
    chk("R12 cascade vector", vectorOut, 8'hA2);
    chk("R12 cascade flag set", cascadeHit, 1);
    wrReg(2'd3, 8'h00);
    wrReg(2'd2, 8'hA0);
    setIrq(2, 0); nextCycle(); setIrq(2, 1); nextCycle();
    ack();
    chk("R12 cascade disabled", cascadeHit, 0);
    wrReg(2'd3, 8'h00);
    irqIn = '0; #1;

    wrReg(2'd0, 8'hFF);
    setIrq(6, 1);
    nextCycle();
    chk("R2 mask write blocks line 6", irqOut, 0);
    wrReg(2'd0, 8'h00);
    ack();
    chk("R2 unmask then grant 6", vectorOut, 8'hA6);
    wrReg(2'd3, 8'h00);
    irqIn = '0; #1;

    wrReg(2'd2, 8'hA1);
    setIrq(0, 1); setIrq(1, 1);
    nextCycle();
    ack();
    chk("R10 rotation starts at 0", vectorOut, 8'hA0);
    wrReg(2'd3, 8'h00);
    setIrq(0, 0); nextCycle(); setIrq(0, 1); nextCycle();
    ack();
    chk("R10 line 0 now lowest", vectorOut, 8'hA1);
    wrReg(2'd3, 8'h00);
    ack();
    chk("R10 line 0 after line 1", vectorOut, 8'hA0);
    wrReg(2'd3, 8'h00);
    nextCycle();
    chk("R10 all served", irqOut, 0);

    nextCycle();
    finishRun();
  end
endmodule